// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a synchronous request port inside a chip and an external self-refreshing memory of 2M words by 16 bits. The memory uses a plain SRAM-style asynchronous pin set. Each accepted request becomes one pin sequence on the memory side. A write drives address, data and byte enables with chip enable low, then pulses the write strobe for a fixed number of clocks. A read drops chip enable and output enable with the data bus released, waits out the access time, and captures the returned word.

Every phase length is a clock count derived at elaboration from a nanosecond minimum and the clock period, rounded up. An elaboration check rejects parameter sets that break a timing bound, such as a write pulse longer than the 1000 ns ceiling. A separate cycle timer spaces consecutive accesses by at least the memory's cycle time. A level-sensitive sleep request parks the memory in its data-losing deep-sleep state while the controller is idle. When the request is withdrawn, the controller waits one cycle time before it takes new work.

Top module: `psram_async_ctl`

## Requirements
- R1: After reset, all active-low memory controls (chip, write, output, lower byte, upper byte, deep sleep) are high, the data bus is not driven, `rd_valid` is low and `req_ready` is high.
- R2: For a write, chip enable, address, byte enables and write data appear one clock before the write strobe falls. The strobe stays low for exactly WP_CYC clocks (10 at the defaults), and `mem_dq_out` holds the write data with `mem_dq_oe` high throughout the pulse.
- R3: Request mask bit 0 enables bits 7:0 through `mem_lb_n` and mask bit 1 enables bits 15:8 through `mem_ub_n`. A write updates only the enabled lanes, and the write strobe never falls with both lane enables high.
- R4: The write strobe never stays low longer than the 1000 ns ceiling. An elaboration check rejects a pulse count that would exceed it.
- R5: During a read, output enable is low and the data bus is released. Output enable is never low while the bus is driven or while the write strobe is low.
- R6: `req_ready` falls in the cycle after acceptance and stays low for at least CYC_CYC-1 clocks. Successive chip-enable falls are at least CYC_CYC clocks apart (14 at the defaults).
- R7: With `sleep_req` high in idle, `mem_zz_n` goes low and `req_ready` low, and no chip enable or write strobe asserts. After `sleep_req` drops, `mem_zz_n` returns high and no access starts until a full cycle time has passed.
- R8: A read's data is captured on the last clock of an ACC_CYC-clock access phase. `rd_valid` is high for exactly one clock, first seen ACC_CYC clocks (14) after the accepting edge.
- R9: In `rd_data`, the byte lanes whose mask bit was clear read as zero.
- R10: A request with an empty mask is accepted and completes, but chip enable and the write strobe never assert. A read of this kind returns zero with `rd_valid`.
- R11: When `req_valid` and `sleep_req` are both high in an idle, ready cycle, the access is taken first. Sleep follows once the controller is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| sleep_req | input | 1 | Level request for deep sleep |
| rd_data | output | 16 | Captured read data, disabled lanes zero |
| rd_valid | output | 1 | One-clock strobe marking `rd_data` valid |
| mem_addr | output | 21 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_zz_n | output | 1 | Deep sleep, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | High when the controller drives the data bus |

## Verification
A stuck or miscounted phase counter appears at once as a write pulse of the wrong length, or as `rd_valid` off its fixed latency, on the very access that uses it. A wrong cycle-timer load appears as a shortened gap between two back-to-back chip-enable falls. A broken state decode appears within a clock as output enable low while the bus is driven, or as chip enable falling while deep sleep is active. A lane-select slip appears only when the data is read back, as a wrong or non-zero byte in a masked lane.

// File: rtl/psram_ctl_pkg.sv
// Package: shared state type and timing helper for the pseudo-SRAM controller.
// Assumes: all timing values are positive nanosecond integers.
package psram_ctl_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_WSETUP  = 3'd1,
        PS_WPULSE  = 3'd2,
        PS_RACCESS = 3'd3,
        PS_SLEEP   = 3'd4
    } psram_state_e;

    // Clock count covering a nanosecond minimum, rounded up, at least one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
// Module: loadable down-counter that flags when it reaches zero.
// Assumes: load has priority; the count rests at zero until reloaded.
module psram_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Count down toward zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_rd_capture.sv
// Module: samples the memory data bus at the end of a read and zeroes
// the byte lanes that were not enabled; raises a one-clock valid strobe.
// Assumes: lane_en is stable in the capture cycle.
module psram_rd_capture #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BYTES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] lane_d;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_d[b*8 +: 8] = lane_en[b] ? dq_in[b*8 +: 8] : 8'h00;
    end

    // Hold the last captured word and pulse valid for the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= lane_d;
        end
    end

    AST_RVALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8

endmodule

// File: rtl/psram_async_ctl.sv
// Module: synchronous front end for an asynchronous SRAM-style pseudo-SRAM.
// Turns one accepted request into a write-strobe or output-enable sequence,
// spaces accesses by the cycle time and handles the deep-sleep pin.
// Assumes: memory outputs are registered here; phase counts come from the
// nanosecond minimums and CLK_PERIOD_NS.
module psram_async_ctl
    import psram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 21,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_ACC_NS      = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_WP_NS       = 50,
    parameter int unsigned T_WP_MAX_NS   = 1000,
    parameter int unsigned T_DW_NS       = 30,
    parameter int unsigned T_CYC_NS      = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              sleep_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_zz_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int unsigned ACC_CYC    = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC     = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_CYC    = ns_to_cyc(T_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_MAX_CYC = T_WP_MAX_NS / CLK_PERIOD_NS;
    localparam int unsigned TMR_W      = $clog2(ACC_CYC + WP_CYC + CYC_CYC + 1);
    localparam int unsigned WLC_W      = $clog2(WP_MAX_CYC + 2);

    // Elaboration checks on the derived timing.
    if (DATA_W != 16) begin : g_bad_width
        $error("psram_async_ctl: two byte lanes require DATA_W of 16");
    end
    if (WP_CYC * CLK_PERIOD_NS > T_WP_MAX_NS) begin : g_bad_wp
        $error("psram_async_ctl: write pulse exceeds its ceiling");
    end
    if (T_DW_NS > WP_CYC * CLK_PERIOD_NS) begin : g_bad_dw
        $error("psram_async_ctl: write pulse shorter than data overlap");
    end
    if (T_OE_NS > ACC_CYC * CLK_PERIOD_NS) begin : g_bad_oe
        $error("psram_async_ctl: access phase shorter than output-enable time");
    end

    psram_state_e state_q;
    logic         phase_load, phase_done;
    logic [TMR_W-1:0] phase_val;
    logic         cyc_load, cyc_done;
    logic         accept, go_sleep, wake, req_sel, capture;
    logic [1:0]   be_n_q;

    assign req_ready = (state_q == PS_IDLE) && cyc_done;
    assign accept    = req_valid && req_ready;
    assign go_sleep  = sleep_req && req_ready && !req_valid;
    assign wake      = (state_q == PS_SLEEP) && !sleep_req;
    assign req_sel   = |req_be;
    assign capture   = (state_q == PS_RACCESS) && phase_done;

    // Phase timer load: write pulse length or read access length.
    always_comb begin
        phase_load = 1'b0;
        phase_val  = '0;
        if (state_q == PS_WSETUP) begin
            phase_load = 1'b1;
            phase_val  = TMR_W'(WP_CYC - 1);
        end else if (accept && !req_write) begin
            phase_load = 1'b1;
            phase_val  = TMR_W'(ACC_CYC - 1);
        end
    end

    assign cyc_load = accept || wake;

    psram_phase_timer #(.W(TMR_W)) phase_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .expired  (phase_done)
    );

    psram_phase_timer #(.W(TMR_W)) cycle_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cyc_load),
        .load_val (TMR_W'(CYC_CYC - 1)),
        .expired  (cyc_done)
    );

    // Sequencer and registered memory-side controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_IDLE;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
            mem_ce_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            be_n_q     <= 2'b11;
            mem_zz_n   <= 1'b1;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (accept) begin
                        mem_addr <= req_addr;
                        be_n_q   <= ~req_be;
                        mem_ce_n <= ~req_sel;
                        if (req_write) begin
                            mem_dq_out <= req_wdata;
                            mem_dq_oe  <= req_sel;
                            state_q    <= PS_WSETUP;
                        end else begin
                            mem_oe_n <= ~req_sel;
                            state_q  <= PS_RACCESS;
                        end
                    end else if (go_sleep) begin
                        mem_zz_n <= 1'b0;
                        state_q  <= PS_SLEEP;
                    end
                end
                PS_WSETUP: begin
                    mem_we_n <= &be_n_q;
                    state_q  <= PS_WPULSE;
                end
                PS_WPULSE: begin
                    if (phase_done) begin
                        mem_we_n  <= 1'b1;
                        mem_ce_n  <= 1'b1;
                        be_n_q    <= 2'b11;
                        mem_dq_oe <= 1'b0;
                        state_q   <= PS_IDLE;
                    end
                end
                PS_RACCESS: begin
                    if (phase_done) begin
                        mem_oe_n <= 1'b1;
                        mem_ce_n <= 1'b1;
                        be_n_q   <= 2'b11;
                        state_q  <= PS_IDLE;
                    end
                end
                PS_SLEEP: begin
                    if (wake) begin
                        mem_zz_n <= 1'b1;
                        state_q  <= PS_IDLE;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign mem_lb_n = be_n_q[0];
    assign mem_ub_n = be_n_q[1];

    psram_rd_capture #(.DATA_W(DATA_W)) rd_cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .lane_en  (~be_n_q),
        .dq_in    (mem_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Checker state: consecutive clocks with the write strobe low, saturating.
    logic [WLC_W-1:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                                   we_low_cnt <= '0;
        else if (mem_we_n)                            we_low_cnt <= '0;
        else if (we_low_cnt != WLC_W'(WP_MAX_CYC + 1)) we_low_cnt <= we_low_cnt + 1'b1;
    end

    AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= WLC_W'(WP_CYC))); // R2
    AST_WE_LANE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(mem_lb_n && mem_ub_n)); // R3
    AST_WE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (we_low_cnt < WLC_W'(WP_MAX_CYC))); // R4
    AST_OE_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n)); // R5
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R6
    AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_zz_n |-> (mem_ce_n && mem_we_n)); // R7

endmodule

// File: tb/psram_async_ctl_tb.sv
// Directed bench: one task per scenario, a small memory model, counters.
module psram_async_ctl_tb_top;

    localparam int CLK_NS  = 5;
    localparam int WP      = (50 + CLK_NS - 1) / CLK_NS;   // 10
    localparam int ACC     = (70 + CLK_NS - 1) / CLK_NS;   // 14
    localparam int CYC     = (70 + CLK_NS - 1) / CLK_NS;   // 14
    localparam int WR_WAIT = (CYC - 1 > WP + 1) ? CYC - 1 : WP + 1;
    localparam int RD_WAIT = (CYC - 1 > ACC) ? CYC - 1 : ACC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic [20:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_zz_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    psram_async_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .sleep_req(sleep_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_zz_n(mem_zz_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: 16 words, writes lanes while chip and strobe are low.
    logic [15:0] arr [0:15];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) arr[i] <= 16'(i * 16'h0101);
        end else if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) arr[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) arr[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
    end
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
        {mem_ub_n ? 8'hA5 : arr[mem_addr[3:0]][15:8],
         mem_lb_n ? 8'h5A : arr[mem_addr[3:0]][7:0]} : 16'hFFFF;

    // Port monitor sampled on falling edges.
    logic [15:0] exp_wdata = '0;
    int  we_run = 0, last_we_len = 0, cyc = 0, ce_falls = 0, last_gap = 0, last_fall = -1;
    bit  ce_prev = 1'b1, data_bad = 1'b0, oe_bad = 1'b0, zz_bad = 1'b0, lane_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                we_run++;
                if (mem_dq_out !== exp_wdata || !mem_dq_oe || !mem_oe_n) data_bad = 1'b1;
                if (mem_lb_n && mem_ub_n) lane_bad = 1'b1;
            end else if (we_run != 0) begin
                last_we_len = we_run;
                we_run = 0;
            end
            if (!mem_oe_n && mem_dq_oe) oe_bad = 1'b1;
            if (!mem_zz_n && (!mem_ce_n || !mem_we_n)) zz_bad = 1'b1;
            if (!mem_ce_n && ce_prev) begin
                ce_falls++;
                if (last_fall >= 0) last_gap = cyc - last_fall;
                last_fall = cyc;
            end
            ce_prev = mem_ce_n;
            cyc++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [20:0] a, input logic [15:0] d,
                            input logic [1:0] be, output int rwait);
        while (!req_ready) @(negedge clk);
        req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        exp_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rwait = 0;
        while (!req_ready) begin @(negedge clk); rwait++; end
    endtask

    task automatic do_read(input logic [20:0] a, input logic [1:0] be,
                           output logic [15:0] d, output int lat, output int rwait);
        while (!req_ready) @(negedge clk);
        req_write = 1'b0; req_addr = a; req_be = be; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rd_valid && lat < 1000) begin @(negedge clk); lat++; end
        d = rd_data;
        rwait = lat;
        while (!req_ready) begin @(negedge clk); rwait++; end
        @(negedge clk);
        chk(!rd_valid, "R8 rd_valid one clock", rd_valid, 0);
    endtask

    task automatic t_reset();
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_zz_n} == 6'h3F,
            "R1 controls idle high", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_zz_n}, 6'h3F);
        chk(!mem_dq_oe && !rd_valid, "R1 bus released, no valid", {mem_dq_oe, rd_valid}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_write_read();
        int w, lat, rw; logic [15:0] d;
        do_write(21'd3, 16'hBEEF, 2'b11, w);
        chk(last_we_len == WP, "R2 write pulse width", last_we_len, WP);
        chk(last_we_len * CLK_NS <= 1000, "R4 pulse under ceiling", last_we_len * CLK_NS, 1000);
        chk(w == WR_WAIT, "R6 ready low after write", w, WR_WAIT);
        do_read(21'd3, 2'b11, d, lat, rw);
        chk(d == 16'hBEEF, "R8 read data", d, 16'hBEEF);
        chk(lat == ACC, "R8 read latency", lat, ACC);
        chk(rw == RD_WAIT, "R6 ready low after read", rw, RD_WAIT);
    endtask

    task automatic t_lanes();
        int w, lat, rw; logic [15:0] d;
        do_write(21'd5, 16'h1234, 2'b11, w);
        do_write(21'd5, 16'hAACD, 2'b01, w);
        do_read(21'd5, 2'b11, d, lat, rw);
        chk(d == 16'h12CD, "R3 lower lane only written", d, 16'h12CD);
        do_write(21'd5, 16'h77EE, 2'b10, w);
        do_read(21'd5, 2'b11, d, lat, rw);
        chk(d == 16'h77CD, "R3 upper lane only written", d, 16'h77CD);
        do_read(21'd5, 2'b01, d, lat, rw);
        chk(d == 16'h00CD, "R9 upper lane zeroed", d, 16'h00CD);
        do_read(21'd5, 2'b10, d, lat, rw);
        chk(d == 16'h7700, "R9 lower lane zeroed", d, 16'h7700);
    endtask

    task automatic t_empty_mask();
        int w, lat, rw, f0; logic [15:0] d;
        f0 = ce_falls;
        do_write(21'd7, 16'hFFFF, 2'b00, w);
        do_read(21'd7, 2'b00, d, lat, rw);
        chk(ce_falls == f0, "R10 no chip enable", ce_falls - f0, 0);
        chk(d == 16'h0000 && lat == ACC, "R10 empty read returns zero", d, 0);
        do_read(21'd7, 2'b11, d, lat, rw);
        chk(d == 16'h0707, "R10 word untouched", d, 16'h0707);
    endtask

    task automatic t_back_to_back();
        int w;
        do_write(21'd8, 16'h0A0A, 2'b11, w);
        do_write(21'd9, 16'h0B0B, 2'b11, w);
        chk(last_gap == CYC, "R6 chip-enable spacing", last_gap, CYC);
    endtask

    task automatic t_sleep();
        int n, lat; logic [15:0] d;
        while (!req_ready) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        chk(!mem_zz_n && !req_ready, "R7 sleep entered", {mem_zz_n, req_ready}, 0);
        req_write = 1'b0; req_addr = 21'd9; req_be = 2'b11; req_valid = 1'b1;
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk(mem_ce_n && !mem_zz_n, "R7 request held off in sleep", mem_ce_n, 1);
        sleep_req = 1'b0;
        n = 0;
        while (mem_ce_n && n < 1000) begin @(negedge clk); n++; end
        req_valid = 1'b0;
        chk(mem_zz_n, "R7 sleep released", mem_zz_n, 1);
        chk(n >= CYC, "R7 wake wait", n, CYC);
        lat = 0;
        while (!rd_valid && lat < 1000) begin @(negedge clk); lat++; end
        d = rd_data;
        chk(d == 16'h0B0B, "R7 access after wake", d, 16'h0B0B);
    endtask

    task automatic t_priority();
        while (!req_ready) @(negedge clk);
        sleep_req = 1'b1; req_write = 1'b0; req_addr = 21'd3; req_be = 2'b11; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_zz_n && !mem_ce_n, "R11 access before sleep", {mem_zz_n, mem_ce_n}, 2'b10);
        while (!req_ready && mem_zz_n) @(negedge clk);
        @(negedge clk);
        chk(!mem_zz_n, "R11 sleep follows access", mem_zz_n, 0);
        sleep_req = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_lanes();
        t_empty_mask();
        t_back_to_back();
        t_sleep();
        t_priority();
        chk(!data_bad, "R2 data held during pulse", data_bad, 0);
        chk(!lane_bad, "R3 lane enabled during pulse", lane_bad, 0);
        chk(!oe_bad, "R5 no bus contention", oe_bad, 0);
        chk(!zz_bad, "R7 no access in sleep", zz_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * CLK_NS);
        if (!finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule